// File: doc/BRIEF.md
# Bitwise Logic Unit with Condition-Field Recording

This block computes bit-parallel logic results for a 64-bit integer pipeline. It takes one operation per cycle: a source operand, a second operand or a 16-bit unsigned immediate carried in the low bits of the second operand, an operation code, a record request and the current summary-overflow bit. One cycle later it presents the 64-bit result with a valid strobe.

Selected operations also produce a write of condition field 0. The 4-bit value says whether the result is less than, greater than or equal to zero. The comparison treats the low 32 bits of the result as a signed number and ignores the upper 32 bits. The fourth bit is a copy of the summary-overflow input. The block has no carry or overflow outputs, so it cannot change those exception-register bits. Decode and the register file sit outside the block.

Top module: `bitop_flag_unit`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it rises, `outValid` and `crWrEn` are 0, and `result` and `crVal` are all zeros.
- R2: `outValid` equals `inValid` delayed by one clock cycle. `result`, `crVal` and `crWrEn` change only on an edge where `inValid` is 1, and hold otherwise, except that `crWrEn` drops to 0 whenever `outValid` is 0.
- R3: The register codes are 0 (AND), 1 (OR), 2 (XOR), 3 (NAND) and 4 (NOR). Each one operates on all 64 bits of `srcA` and `srcB`.
- R4: Codes 5 (AND), 7 (OR) and 9 (XOR) combine `srcA` with `srcB[15:0]` zero-extended into bits 15:0. `srcB[63:16]` has no effect.
- R5: Codes 6 (AND), 8 (OR) and 10 (XOR) combine `srcA` with `srcB[15:0]` placed in bits 31:16, with zeros in every other bit.
- R6: For codes 0 to 4, `crWrEn` equals the `recordEn` value presented with the operation.
- R7: Codes 5 and 6 always assert `crWrEn`, whatever `recordEn` is.
- R8: Codes 7, 8, 9 and 10 never assert `crWrEn`, whatever `recordEn` is.
- R9: `crVal[3]` is less-than, `crVal[2]` is greater-than and `crVal[1]` is equal. They are set from a signed compare against zero of `result[31:0]` sign-extended, so exactly one of them is set. `result[63:32]` has no effect on them.
- R10: `crVal[0]` equals the `sumOvf` value presented with the operation.
- R11: Codes 11 to 15 give a zero result and never assert `crWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code |
| recordEn | input | 1 | Record request for the register forms |
| srcA | input | 64 | Source operand |
| srcB | input | 64 | Second operand; bits 15:0 are the immediate |
| sumOvf | input | 1 | Current summary-overflow bit |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Logic result |
| crWrEn | output | 1 | Write enable for condition field 0 |
| crVal | output | 4 | {LT, GT, EQ, SO} value for condition field 0 |

## Verification
The bound checker watches every cycle for the following:
- the one-cycle valid delay;
- the record rules for the register, AND-immediate and OR/XOR-immediate codes;
- exactly one compare flag set on each write;
- the copy of summary-overflow;
- the zero upper half after an AND with an immediate;
- the zero, non-recording behaviour of the unused codes.

Only the directed scenarios can show that each function and each immediate placement gives the right bits. The same goes for the compare following the sign-extended low word, for example less-than when bit 31 is set and the upper word is zero, or equal when only the upper word is nonzero. They also show that outputs hold when no operation is presented.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

  localparam int OP_W = 4;

  localparam logic [OP_W-1:0] OP_AND   = 4'd0;
  localparam logic [OP_W-1:0] OP_OR    = 4'd1;
  localparam logic [OP_W-1:0] OP_XOR   = 4'd2;
  localparam logic [OP_W-1:0] OP_NAND  = 4'd3;
  localparam logic [OP_W-1:0] OP_NOR   = 4'd4;
  localparam logic [OP_W-1:0] OP_ANDI  = 4'd5;
  localparam logic [OP_W-1:0] OP_ANDIH = 4'd6;
  localparam logic [OP_W-1:0] OP_ORI   = 4'd7;
  localparam logic [OP_W-1:0] OP_ORIH  = 4'd8;
  localparam logic [OP_W-1:0] OP_XORI  = 4'd9;
  localparam logic [OP_W-1:0] OP_XORIH = 4'd10;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_NAND = 3'd3,
    FN_NOR  = 3'd4,
    FN_ZERO = 3'd5
  } fn_e;

  typedef struct packed {
    fn_e  fn;
    logic useImm;
    logic immHigh;
    logic recordOn;
  } strobe_t;

endpackage

// File: rtl/bitop_ctrl.sv
module bitop_ctrl
  import bitop_pkg::*;
(
  input  logic [OP_W-1:0] opCode,
  input  logic            recordEn,
  output strobe_t         strobes
);

  always_comb begin
    strobes.fn       = FN_ZERO;
    strobes.useImm   = 1'b0;
    strobes.immHigh  = 1'b0;
    strobes.recordOn = 1'b0;
    unique case (opCode)
      OP_AND:   begin strobes.fn = FN_AND;  strobes.recordOn = recordEn; end
      OP_OR:    begin strobes.fn = FN_OR;   strobes.recordOn = recordEn; end
      OP_XOR:   begin strobes.fn = FN_XOR;  strobes.recordOn = recordEn; end
      OP_NAND:  begin strobes.fn = FN_NAND; strobes.recordOn = recordEn; end
      OP_NOR:   begin strobes.fn = FN_NOR;  strobes.recordOn = recordEn; end
      OP_ANDI:  begin strobes.fn = FN_AND; strobes.useImm = 1'b1; strobes.recordOn = 1'b1; end
      OP_ANDIH: begin strobes.fn = FN_AND; strobes.useImm = 1'b1; strobes.immHigh = 1'b1;
                      strobes.recordOn = 1'b1; end
      OP_ORI:   begin strobes.fn = FN_OR;  strobes.useImm = 1'b1; end
      OP_ORIH:  begin strobes.fn = FN_OR;  strobes.useImm = 1'b1; strobes.immHigh = 1'b1; end
      OP_XORI:  begin strobes.fn = FN_XOR; strobes.useImm = 1'b1; end
      OP_XORIH: begin strobes.fn = FN_XOR; strobes.useImm = 1'b1; strobes.immHigh = 1'b1; end
      default:  begin strobes.fn = FN_ZERO; end
    endcase
  end

endmodule

// File: rtl/bitop_crgen.sv
module bitop_crgen #(
  parameter int DATA_W = 64,
  parameter int CMP_W  = 32
) (
  input  logic [DATA_W-1:0] res,
  input  logic              sumOvf,
  output logic [3:0]        flags
);

  localparam int EXT_W = DATA_W - CMP_W;

  logic signed [DATA_W-1:0] extended;

  generate
    if (EXT_W > 0) begin : g_ext
      assign extended = {{EXT_W{res[CMP_W-1]}}, res[CMP_W-1:0]};
    end else begin : g_full
      assign extended = res;
    end
  endgenerate

  logic isNeg, isZero;
  assign isNeg  = extended < 0;
  assign isZero = extended == '0;

  assign flags = {isNeg, !isNeg && !isZero, isZero, sumOvf};

endmodule

// File: rtl/bitop_datapath.sv
module bitop_datapath
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int CMP_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  strobe_t           strobes,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              sumOvf,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              crWrEn,
  output logic [3:0]        crVal
);

  localparam int HIGH_LSB = IMM_W;
  localparam int HIGH_PAD = DATA_W - 2 * IMM_W;

  logic [DATA_W-1:0] immLow, immHigh, operandB, nextRes;
  logic [3:0]        nextFlags;
  logic              recordQ;

  assign immLow = {{(DATA_W - IMM_W){1'b0}}, srcB[IMM_W-1:0]};

  generate
    if (HIGH_PAD > 0) begin : g_pad
      assign immHigh = {{HIGH_PAD{1'b0}}, srcB[IMM_W-1:0], {HIGH_LSB{1'b0}}};
    end else begin : g_nopad
      assign immHigh = {srcB[IMM_W-1:0], {HIGH_LSB{1'b0}}};
    end
  endgenerate

  always_comb begin
    if (!strobes.useImm)     operandB = srcB;
    else if (strobes.immHigh) operandB = immHigh;
    else                      operandB = immLow;
  end

  always_comb begin
    unique case (strobes.fn)
      FN_AND:  nextRes = srcA & operandB;
      FN_OR:   nextRes = srcA | operandB;
      FN_XOR:  nextRes = srcA ^ operandB;
      FN_NAND: nextRes = ~(srcA & operandB);
      FN_NOR:  nextRes = ~(srcA | operandB);
      default: nextRes = '0;
    endcase
  end

  bitop_crgen #(.DATA_W(DATA_W), .CMP_W(CMP_W)) i_crgen (
    .res    (nextRes),
    .sumOvf (sumOvf),
    .flags  (nextFlags)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      crVal    <= '0;
      recordQ  <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= nextRes;
        crVal   <= nextFlags;
        recordQ <= strobes.recordOn;
      end
    end
  end

  assign crWrEn = outValid && recordQ;

endmodule

// File: rtl/bitop_flag_unit.sv
module bitop_flag_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16,
  parameter int CMP_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              recordEn,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic              sumOvf,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              crWrEn,
  output logic [3:0]        crVal
);

  strobe_t strobes;

  bitop_ctrl i_ctrl (
    .opCode   (opCode),
    .recordEn (recordEn),
    .strobes  (strobes)
  );

  bitop_datapath #(.DATA_W(DATA_W), .IMM_W(IMM_W), .CMP_W(CMP_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobes  (strobes),
    .srcA     (srcA),
    .srcB     (srcB),
    .sumOvf   (sumOvf),
    .outValid (outValid),
    .result   (result),
    .crWrEn   (crWrEn),
    .crVal    (crVal)
  );

endmodule

// File: rtl/bitop_flag_unit_chk.sv
module bitop_flag_unit_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [3:0]        opCode,
  input logic              recordEn,
  input logic              sumOvf,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              crWrEn,
  input logic [3:0]        crVal
);

  assert_valid_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> outValid == $past(inValid));

  assert_no_write_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> !crWrEn);

  assert_reg_record_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode <= 4'd4) |=> crWrEn == $past(recordEn));

  assert_andi_records_R7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode == 4'd5 || opCode == 4'd6)) |=> crWrEn);

  assert_ori_xori_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode >= 4'd7 && opCode <= 4'd10) |=> !crWrEn);

  assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    crWrEn |-> $countones(crVal[3:1]) == 1);

  assert_so_copy_R10: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> crVal[0] == $past(sumOvf));

  assert_andi_upper_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opCode == 4'd5 || opCode == 4'd6)) |=> result[DATA_W-1:32] == '0);

  assert_unused_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opCode >= 4'd11) |=> (result == '0 && !crWrEn));

endmodule

bind bitop_flag_unit bitop_flag_unit_chk #(.DATA_W(DATA_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .opCode   (opCode),
  .recordEn (recordEn),
  .sumOvf   (sumOvf),
  .outValid (outValid),
  .result   (result),
  .crWrEn   (crWrEn),
  .crVal    (crVal)
);

// File: tb/test_bitop_flag_unit.sv
`timescale 1ns/1ps
module test_bitop_flag_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic        recordEn = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        sumOvf = 1'b0;
  logic        outValid;
  logic [63:0] result;
  logic        crWrEn;
  logic [3:0]  crVal;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bitop_flag_unit i_bitop_flag_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .recordEn(recordEn), .srcA(srcA), .srcB(srcB), .sumOvf(sumOvf),
    .outValid(outValid), .result(result), .crWrEn(crWrEn), .crVal(crVal)
  );

  function automatic logic [63:0] modelRes(input logic [3:0] op, input logic [63:0] a,
                                           input logic [63:0] b);
    logic [63:0] lo, hi;
    lo = {48'h0, b[15:0]};
    hi = {32'h0, b[15:0], 16'h0};
    case (op)
      4'd0: return a & b;
      4'd1: return a | b;
      4'd2: return a ^ b;
      4'd3: return ~(a & b);
      4'd4: return ~(a | b);
      4'd5: return a & lo;
      4'd6: return a & hi;
      4'd7: return a | lo;
      4'd8: return a | hi;
      4'd9: return a ^ lo;
      4'd10: return a ^ hi;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic [3:0] modelCr(input logic [63:0] r, input logic so);
    int signed low;
    low = r[31:0];
    return {low < 0, low > 0, low == 0, so};
  endfunction

  function automatic logic modelWr(input logic [3:0] op, input logic rec);
    if (op <= 4'd4) return rec;
    if (op == 4'd5 || op == 4'd6) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [3:0] op, input logic rec, input logic [63:0] a,
                       input logic [63:0] b, input logic so);
    @(negedge clk);
    inValid = 1'b1; opCode = op; recordEn = rec; srcA = a; srcB = b; sumOvf = so;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic opAndCheck(input string req, input logic [3:0] op, input logic rec,
                            input logic [63:0] a, input logic [63:0] b, input logic so);
    logic [63:0] er;
    runOp(op, rec, a, b, so);
    er = modelRes(op, a, b);
    check(req, result, er);
    check(req, {63'h0, crWrEn}, {63'h0, modelWr(op, rec)});
    check(req, {60'h0, crVal}, {60'h0, modelCr(er, so)});
  endtask

  task automatic tReset();
    check("R1 outValid", {63'h0, outValid}, 64'h0);
    check("R1 crWrEn", {63'h0, crWrEn}, 64'h0);
    check("R1 result", result, 64'h0);
    check("R1 crVal", {60'h0, crVal}, 64'h0);
  endtask

  task automatic tRegOps();
    for (int op = 0; op < 5; op++) begin
      opAndCheck("R3 reg op", op[3:0], 1'b0, 64'hF0F0_1234_AAAA_0F0F, 64'hFF00_5678_5555_00FF, 1'b0);
      opAndCheck("R3 reg op alt", op[3:0], 1'b1, 64'h8000_0000_0000_0001, 64'h0000_0001_FFFF_FFFF, 1'b1);
    end
  endtask

  task automatic tImmPlain();
    opAndCheck("R4 andi", 4'd5, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hDEAD_BEEF_CAFE_8421, 1'b0);
    opAndCheck("R4 ori", 4'd7, 1'b1, 64'h1234_0000_0000_0000, 64'hFFFF_FFFF_FFFF_00F0, 1'b0);
    opAndCheck("R4 xori", 4'd9, 1'b0, 64'h0000_0000_0000_FFFF, 64'h0123_4567_89AB_0F0F, 1'b1);
  endtask

  task automatic tImmShift();
    opAndCheck("R5 andis", 4'd6, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hAAAA_BBBB_CCCC_8421, 1'b0);
    opAndCheck("R5 oris", 4'd8, 1'b1, 64'h0, 64'hFFFF_FFFF_FFFF_00F0, 1'b0);
    opAndCheck("R5 xoris", 4'd10, 1'b0, 64'h5555_5555_5555_5555, 64'h0000_0000_0000_FFFF, 1'b0);
  endtask

  task automatic tRecordRules();
    opAndCheck("R6 no record", 4'd1, 1'b0, 64'h5, 64'h0, 1'b0);
    opAndCheck("R6 record", 4'd4, 1'b1, 64'h5, 64'h0, 1'b0);
    opAndCheck("R7 andi rec=0", 4'd5, 1'b0, 64'h0, 64'hFFFF, 1'b0);
    opAndCheck("R7 andis rec=0", 4'd6, 1'b0, 64'h8000_0000, 64'h8000, 1'b0);
    opAndCheck("R8 ori rec=1", 4'd7, 1'b1, 64'h1, 64'h1, 1'b0);
    opAndCheck("R8 xoris rec=1", 4'd10, 1'b1, 64'h1, 64'h1, 1'b0);
  endtask

  task automatic tCrSign();
    runOp(4'd1, 1'b1, 64'h0000_0000_8000_0000, 64'h0, 1'b0);
    check("R9 bit31 upper zero -> LT", {60'h0, crVal}, {60'h0, 4'b1000});
    runOp(4'd0, 1'b1, 64'hFFFF_0000_0000_0000, 64'hFFFF_0000_0000_0000, 1'b0);
    check("R9 upper only -> EQ", {60'h0, crVal}, {60'h0, 4'b0010});
    runOp(4'd2, 1'b1, 64'h8000_0000_0000_0000, 64'h0000_0000_7FFF_FFFF, 1'b1);
    check("R9 R10 negative upper -> GT,SO", {60'h0, crVal}, {60'h0, 4'b0101});
    runOp(4'd3, 1'b1, 64'h0, 64'h0, 1'b1);
    check("R9 R10 nand all ones -> LT,SO", {60'h0, crVal}, {60'h0, 4'b1001});
  endtask

  task automatic tUnused();
    for (int op = 11; op < 16; op++)
      opAndCheck("R11 unused code", op[3:0], 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
  endtask

  task automatic tLatency();
    logic [63:0] held;
    @(negedge clk);
    inValid = 1'b1; opCode = 4'd2; recordEn = 1'b1; srcA = 64'h1111; srcB = 64'h2222; sumOvf = 1'b0;
    check("R2 not yet valid", {63'h0, outValid}, 64'h0);
    @(negedge clk);
    check("R2 valid after one cycle", {63'h0, outValid}, 64'h1);
    check("R2 result", result, 64'h3333);
    held = result;
    inValid = 1'b0; opCode = 4'd1; srcA = 64'hFFFF; srcB = 64'h0; sumOvf = 1'b1;
    @(negedge clk);
    check("R2 valid drops", {63'h0, outValid}, 64'h0);
    check("R2 result held", result, held);
    check("R2 crWrEn low when idle", {63'h0, crWrEn}, 64'h0);
    check("R2 crVal held", {60'h0, crVal}, {60'h0, 4'b0100});
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tLatency();
    tRegOps();
    tImmPlain();
    tImmShift();
    tRecordRules();
    tCrSign();
    tUnused();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule